// File: doc/BRIEF.md
# Stable-Partition Pass Mask Generator

This block works out how to realise an arbitrary reordering of N bits (N = 8 by default) as a chain of stable two-way partition passes. A partition pass takes a data word and a control mask. It collects the bits whose control bit is 0, keeping their order, and follows them with the bits whose control bit is 1, also keeping their order. The block receives the wanted final arrangement as N source indices of log2(N) bits each. Entry j names the input bit that must end up at position j. It returns the control masks that software or a datapath then applies.

The engine works backwards from the target arrangement. On every iteration it cuts the current arrangement into maximal strictly increasing runs. It joins run i with run i+m, where m is half the run count rounded up, and sorts each joined group into increasing order. The concatenated groups form the arrangement that comes one pass earlier. The pass mask marks which elements of that earlier arrangement came from the later half of the runs. Each iteration at least halves the run count, so a permutation of N elements needs no more than log2(N) masks. Iteration stops when a single run is left. The masks are reported in the order they were generated and are applied last-first.

Top module: `perm_ctl_gen`

## Requirements
- R1: After reset, done_o, mask_cnt_o and masks_o are all zero.
- R2: A start_i pulse while no computation is running loads target_i, clears done_o, mask_cnt_o and masks_o, and begins computation. A start_i while a computation is running has no effect on its results or timing.
- R3: Positions are grouped into maximal runs. A new run begins at position 0 and at every position j whose entry is less than or equal to the entry at position j-1.
- R4: With k runs and m = ceil(k/2), runs are numbered from 0. Run i (i < m) is merged with run i+m when that run exists. Each merged group is sorted increasing, with ties keeping position order. The groups, concatenated in order, form the previous arrangement. For target (7,6,5,4,3,2,0,1) the previous arrangements are (3,7,2,6,0,1,5,4) and then (0,1,3,5,7,2,4,6).
- R5: In each pass mask, bit j is 1 exactly when element j of the previous arrangement came from run m or later. Mask g occupies masks_o[g*N +: N], with bit j of that slice being position j. For target (7,6,5,4,3,2,0,1) the masks are 8'h35, 8'h4B, 8'h54.
- R6: Applying the masks to the identity arrangement from slot mask_cnt_o-1 down to slot 0 reproduces any target permutation. Each application is a stable partition that places control-0 elements first.
- R7: A target that is already a single increasing run (such as the identity) yields mask_cnt_o = 0.
- R8: mask_cnt_o never exceeds log2(N). Computation also ends after log2(N) masks for a target with repeated indices.
- R9: done_o rises exactly 3*c+1 clock edges after the edge that samples an accepted start, where c is the final mask count. It stays high until the next accepted start, with masks_o and mask_cnt_o held stable.
- R10: Mask slots at index mask_cnt_o and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a computation on target_i |
| target_i | input | N*log2(N) | Target arrangement, entry j at bits [j*log2(N) +: log2(N)] |
| masks_o | output | log2(N)*N | Pass masks in generation order |
| mask_cnt_o | output | clog2(log2(N)+1) | Number of valid masks |
| done_o | output | 1 | Result valid, held until next start |

## Verification
The assertions check on every cycle that the count never exceeds log2(N) and that it advances by one per emitted mask. They also check that done and the results hold until a new start, and that each sort keeps the number of late-half elements of the scan. Only the bench scenarios can show that the runs, the pairing and the sorting are correct in value. They do this by comparing against the worked example, by replaying the emitted masks through a stable-partition model for random permutations, and by timing done against an independent model, including a start pulse issued mid-computation.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SORT = 2'd2,
    ST_EMIT = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgen_run_scan.sv
module pgen_run_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N*IW-1:0] arr_i,
  output logic [N*IW-1:0] grp_o,
  output logic [N-1:0]    late_o,
  output logic            single_o
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  brk;
  logic [CW-1:0] rid [N];
  logic [CW-1:0] k_w;
  logic [CW-1:0] half_w;

  // a run breaks where the sequence fails to strictly increase (R3)
  assign brk[0] = 1'b1;
  generate
    for (genvar j = 1; j < N; j++) begin : g_brk
      assign brk[j] = (arr_i[j*IW +: IW] <= arr_i[(j-1)*IW +: IW]);
    end
  endgenerate

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      if (brk[j]) acc = acc + CW'(1);
      rid[j] = acc - CW'(1);
    end
    k_w = acc;
  end

  assign half_w   = CW'((k_w + CW'(1)) >> 1);
  assign single_o = (k_w == CW'(1));

  // run i pairs with run i+half (R4)
  generate
    for (genvar j = 0; j < N; j++) begin : g_grp
      always_comb begin
        if (rid[j] >= half_w) begin
          late_o[j]           = 1'b1;
          grp_o[j*IW +: IW]   = IW'(rid[j] - half_w);
        end else begin
          late_o[j]           = 1'b0;
          grp_o[j*IW +: IW]   = IW'(rid[j]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pgen_rank_sort.sv
module pgen_rank_sort #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N*IW-1:0] arr_i,
  input  logic [N*IW-1:0] grp_i,
  input  logic [N-1:0]    late_i,
  output logic [N*IW-1:0] arr_o,
  output logic [N-1:0]    mask_o
);
  localparam int KW = 2 * IW;

  logic [KW-1:0] key  [N];
  logic [IW-1:0] rank [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_key
      assign key[i] = {grp_i[i*IW +: IW], arr_i[i*IW +: IW]};
    end
    for (genvar i = 0; i < N; i++) begin : g_rank
      always_comb begin
        rank[i] = '0;
        for (int j = 0; j < N; j++) begin
          if ((key[j] < key[i]) || ((key[j] == key[i]) && (j < i)))
            rank[i] = rank[i] + IW'(1);
        end
      end
    end
  endgenerate

  // scatter each element to its sorted slot (R4, R5)
  always_comb begin
    arr_o  = '0;
    mask_o = '0;
    for (int i = 0; i < N; i++) begin
      arr_o[rank[i]*IW +: IW] = arr_i[i*IW +: IW];
      mask_o[rank[i]]         = late_i[i];
    end
  end
endmodule

// File: rtl/perm_ctl_gen.sv
module perm_ctl_gen #(
  parameter int N = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [N*$clog2(N)-1:0]                target_i,
  output logic [$clog2(N)*N-1:0]                masks_o,
  output logic [$clog2($clog2(N)+1)-1:0]        mask_cnt_o,
  output logic                                  done_o
);
  import pgen_pkg::*;

  localparam int IW    = $clog2(N);
  localparam int NPASS = IW;
  localparam int CNTW  = $clog2(NPASS + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  pg_state_e           state_q, state_d;
  logic [N*IW-1:0]     arr_q, arr_d;
  logic                arr_en;
  logic [N*IW-1:0]     grp_q;
  logic [N-1:0]        late_q;
  logic                scan_en;
  logic [N-1:0]        mask_q;
  logic                mask_en;
  logic [NPASS*N-1:0]  list_q, list_d;
  logic                list_en;
  logic [CNTW-1:0]     cnt_q, cnt_d;
  logic                done_q, done_d;

  logic [N*IW-1:0]     grp_w;
  logic [N-1:0]        late_w;
  logic                single_w;
  logic [N*IW-1:0]     sorted_w;
  logic [N-1:0]        smask_w;

  pgen_run_scan #(.N(N), .IW(IW)) u_scan (
    .arr_i    (arr_q),
    .grp_o    (grp_w),
    .late_o   (late_w),
    .single_o (single_w)
  );

  pgen_rank_sort #(.N(N), .IW(IW)) u_sort (
    .arr_i  (arr_q),
    .grp_i  (grp_q),
    .late_i (late_q),
    .arr_o  (sorted_w),
    .mask_o (smask_w)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    arr_d   = arr_q;
    arr_en  = 1'b0;
    scan_en = 1'b0;
    mask_en = 1'b0;
    list_d  = list_q;
    list_en = 1'b0;
    cnt_d   = cnt_q;
    done_d  = done_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SCAN;
          arr_d   = target_i;
          arr_en  = 1'b1;
          list_d  = '0;
          list_en = 1'b1;
          cnt_d   = '0;
          done_d  = 1'b0;
        end
      end
      ST_SCAN: begin
        if (single_w || (cnt_q == CNTW'(NPASS))) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_SORT;
          scan_en = 1'b1;
        end
      end
      ST_SORT: begin
        arr_d   = sorted_w;
        arr_en  = 1'b1;
        mask_en = 1'b1;
        state_d = ST_EMIT;
      end
      default: begin
        list_d[cnt_q*N +: N] = mask_q;
        list_en = 1'b1;
        cnt_d   = cnt_q + CNTW'(1);
        state_d = ST_SCAN;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      arr_q   <= '0;
      grp_q   <= '0;
      late_q  <= '0;
      mask_q  <= '0;
      list_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (arr_en)  arr_q  <= arr_d;
      if (scan_en) begin
        grp_q  <= grp_w;
        late_q <= late_w;
      end
      if (mask_en) mask_q <= smask_w;
      if (list_en) list_q <= list_d;
    end
  end

  assign masks_o    = list_q;
  assign mask_cnt_o = cnt_q;
  assign done_o     = done_q;

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n_s)
    mask_cnt_o <= CNTW'(NPASS));

  a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_EMIT) |=> (mask_cnt_o == $past(mask_cnt_o) + CNTW'(1)));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && !start_i) |=> done_o);

  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && !start_i) |=> ($stable(masks_o) && $stable(mask_cnt_o)));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && state_q == ST_IDLE) |=> (!done_o && mask_cnt_o == '0 && masks_o == '0));

  a_r5_late_weight: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_SORT) |=> ($countones(mask_q) == $countones($past(late_q))));
endmodule

// File: tb/tb_perm_ctl_gen.sv
module tb_perm_ctl_gen;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int NP = 3;

  logic clk, rst_n, start;
  logic [N*IW-1:0] tgt;
  logic [NP*N-1:0] masks;
  logic [1:0]      cnt;
  logic            done;

  int total = 0;
  int bad = 0;

  perm_ctl_gen #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(tgt),
    .masks_o(masks), .mask_cnt_o(cnt), .done_o(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  // reference: backward generation with explicit run lists
  function automatic void ref_gen(input int t[N], output int ms[NP], output int c);
    int cur[N]; int nxt[N]; int rs[N][N]; int rl[N]; int k; int m; int pos;
    int tv[N]; int tf[N]; int len; int kv; int kf; int b; int mk;
    cur = t; c = 0;
    for (int z = 0; z < NP; z++) ms[z] = 0;
    while (c < NP) begin
      k = 0;
      for (int j = 0; j < N; j++) begin
        if (j == 0 || cur[j] <= cur[j-1]) begin k++; rl[k-1] = 0; end
        rs[k-1][rl[k-1]] = cur[j];
        rl[k-1]++;
      end
      if (k == 1) break;
      m = (k + 1) / 2;
      pos = 0; mk = 0;
      for (int g = 0; g < m; g++) begin
        len = 0;
        for (int a = 0; a < rl[g]; a++) begin tv[len] = rs[g][a]; tf[len] = 0; len++; end
        if (g + m < k)
          for (int a = 0; a < rl[g+m]; a++) begin tv[len] = rs[g+m][a]; tf[len] = 1; len++; end
        for (int a = 1; a < len; a++) begin
          kv = tv[a]; kf = tf[a]; b = a - 1;
          while (b >= 0 && tv[b] > kv) begin tv[b+1] = tv[b]; tf[b+1] = tf[b]; b--; end
          tv[b+1] = kv; tf[b+1] = kf;
        end
        for (int a = 0; a < len; a++) begin
          nxt[pos] = tv[a];
          if (tf[a] != 0) mk = mk | (1 << pos);
          pos++;
        end
      end
      ms[c] = mk; c++; cur = nxt;
    end
  endfunction

  function automatic void part(inout int a[N], input int mk);
    int o[N]; int p;
    p = 0;
    for (int j = 0; j < N; j++) if (((mk >> j) & 1) == 0) begin o[p] = a[j]; p++; end
    for (int j = 0; j < N; j++) if (((mk >> j) & 1) == 1) begin o[p] = a[j]; p++; end
    a = o;
  endfunction

  task automatic run_case(input int t[N], input bit is_perm, input bit poke);
    int ms[NP]; int c; int lim; int a[N]; bit same;
    ref_gen(t, ms, c);
    @(negedge clk);
    for (int j = 0; j < N; j++) tgt[j*IW +: IW] = IW'(t[j]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = 3 * c + 2;
    for (int n = 1; n <= lim + 2; n++) begin
      if (n > 1) @(negedge clk);
      if (poke && c > 0 && n == 2) begin
        tgt = ~tgt;
        start = 1'b1;
      end
      if (poke && n == 3) start = 1'b0;
      chk(done == (n >= lim), "R9 done timing", int'(done), int'(n >= lim));
      if (n >= lim) begin
        chk(int'(cnt) == c, "R8 mask count", int'(cnt), c);
        for (int g = 0; g < NP; g++) begin
          if (g < c) chk(int'(masks[g*N +: N]) == ms[g], "R5 mask value", int'(masks[g*N +: N]), ms[g]);
          else chk(masks[g*N +: N] == '0, "R10 unused slot zero", int'(masks[g*N +: N]), 0);
        end
      end
    end
    if (is_perm) begin
      for (int j = 0; j < N; j++) a[j] = j;
      for (int g = int'(cnt) - 1; g >= 0; g--) part(a, int'(masks[g*N +: N]));
      same = 1'b1;
      for (int j = 0; j < N; j++) if (a[j] != t[j]) same = 1'b0;
      chk(same, "R6 replay reproduces target", int'(same), 1);
    end
  endtask

  initial begin
    int t[N]; int a[N]; int ms[NP]; int c; int sw; int r; bit same;
    rst_n = 1'b0; start = 1'b0; tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(cnt == '0, "R1 count", int'(cnt), 0);
    chk(masks == '0, "R1 masks", int'(masks), 0);

    // R3 R4 R5 worked example
    t = '{7, 6, 5, 4, 3, 2, 0, 1};
    ref_gen(t, ms, c);
    chk(c == 3 && ms[0] == 'h35 && ms[1] == 'h4B && ms[2] == 'h54, "R5 model example", ms[0], 'h35);
    run_case(t, 1'b1, 1'b0);
    chk(masks[7:0] == 8'h35, "R3 first mask", int'(masks[7:0]), 'h35);
    chk(masks[15:8] == 8'h4B, "R4 second mask", int'(masks[15:8]), 'h4B);
    chk(masks[23:16] == 8'h54, "R5 third mask", int'(masks[23:16]), 'h54);
    for (int j = 0; j < N; j++) a[j] = j;
    part(a, int'(masks[23:16]));
    same = (a == '{0, 1, 3, 5, 7, 2, 4, 6});
    chk(same, "R4 earlier arrangement", int'(same), 1);
    part(a, int'(masks[15:8]));
    same = (a == '{3, 7, 2, 6, 0, 1, 5, 4});
    chk(same, "R4 intermediate arrangement", int'(same), 1);

    // R7 identity
    t = '{0, 1, 2, 3, 4, 5, 6, 7};
    run_case(t, 1'b1, 1'b0);
    chk(cnt == '0, "R7 identity no masks", int'(cnt), 0);

    // R2 start during computation ignored
    t = '{7, 6, 5, 4, 3, 2, 1, 0};
    run_case(t, 1'b1, 1'b1);
    t = '{1, 2, 5, 7, 0, 3, 6, 4};
    run_case(t, 1'b1, 1'b1);

    // R8 repeated indices still terminate
    t = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_case(t, 1'b0, 1'b0);
    chk(cnt == 2'd3, "R8 repeats capped", int'(cnt), 3);
    chk(masks[7:0] == 8'hAA, "R8 repeats mask", int'(masks[7:0]), 'hAA);

    // R6 random permutations
    for (int it = 0; it < 30; it++) begin
      for (int j = 0; j < N; j++) t[j] = j;
      for (int j = N - 1; j > 0; j--) begin
        r = int'($urandom_range(j, 0));
        sw = t[j]; t[j] = t[r]; t[r] = sw;
      end
      run_case(t, 1'b1, it[0]);
    end
    finish_run();
  end
endmodule